// File: doc/BRIEF.md
# GPIO Pin Ownership Manager

This block decides, for every chip pin, which of two GPIO controllers drives it. One is the general system GPIO and the other is a CPU-local fast GPIO. The block also decides which of the two controllers may see the pin's input value. Each pin has its own configuration word behind a simple register write/read interface. The words are grouped into ports of pins. From the stored words, the block steers the owning controller's output value and output enable to the pad. It also masks the pad input on its way back to each controller.

Each word has an owner bit, two hide bits (one per controller) and a sticky lock bit. Once the lock bit is set, the word is frozen until reset. Pad electrical settings, alternate-function muxing and the GPIO controllers themselves sit outside this block.

Top module: `gpio_own_mgr`

## Requirements
- R1: After reset every configuration word reads 0. Every pad then takes its output value and output enable from the system GPIO, and both controllers see the pad input.
- R2: The word for pin p of port k sits at byte address k*PINS_PER_PORT*4 + p*4, which is k*0x80 + p*4 with 32 pins per port. Address bits [1:0] are ignored. A write to an unlocked word is visible on `reg_rdata` in the next cycle.
- R3: Bit 0 of a word picks the pad owner. With 0, `pad_out` and `pad_oe` follow `sys_out` and `sys_oe`. With 1, they follow `fast_out` and `fast_oe`. The other controller's outputs have no effect on that pin.
- R4: Bit 8 set forces that pin's `sys_in` bit to 0. Bit 8 clear passes the pad input through.
- R5: Bit 9 set forces that pin's `fast_in` bit to 0. Bit 9 clear passes the pad input through.
- R6: Bit 31 set freezes every field of that word. Later writes, including writes of 0 to bit 31, leave the word unchanged.
- R7: The write that sets bit 31 also stores bits 0, 8 and 9 from the same write data.
- R8: Only reset clears bit 31. After reset the word can be written again.
- R9: All bits other than 31, 9, 8 and 0 read as 0, and writes to them are dropped.
- R10: A new configuration changes the pad and input routing in the cycle right after the write edge.
- R11: A write changes only the addressed pin's word and routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the addressed word |
| reg_addr | input | ADDR_W | Byte address of a configuration word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Addressed word, combinational read |
| sys_out | input | NUM_PINS | System GPIO output values |
| sys_oe | input | NUM_PINS | System GPIO output enables |
| sys_in | output | NUM_PINS | Masked pad inputs to system GPIO |
| fast_out | input | NUM_PINS | Fast GPIO output values |
| fast_oe | input | NUM_PINS | Fast GPIO output enables |
| fast_in | output | NUM_PINS | Masked pad inputs to fast GPIO |
| pad_in | input | NUM_PINS | Pad input values |
| pad_out | output | NUM_PINS | Pad output values |
| pad_oe | output | NUM_PINS | Pad output enables |

## Verification
Several properties are checked on every cycle, for every pin. A locked word never unlocks and never changes. An unlocked word takes the written fields. The pad always follows the controller named by the owner bit. A hidden controller always sees 0. Some behaviours need the bench's scenarios: the address map with ignored low bits, dropping of unimplemented bits, the lock set together with other fields, routing in the cycle right after a write, independence from neighbouring pins, and release of the lock by reset.

// File: rtl/gpio_own_pkg.sv
// Package: shared configuration type and field positions for the pin
// ownership manager. Assumes a 32-bit register word.
package gpio_own_pkg;

    localparam int WORD_W        = 32;
    localparam int BIT_OWNER     = 0;
    localparam int BIT_HIDE_SYS  = 8;
    localparam int BIT_HIDE_FAST = 9;
    localparam int BIT_LOCK      = 31;

    typedef struct packed {
        logic lock;
        logic hide_fast;
        logic hide_sys;
        logic owner_fast;
    } pin_cfg_t;

    // Expand the stored fields into a register word, other bits zero.
    function automatic logic [WORD_W-1:0] cfg_to_word(input pin_cfg_t c);
        logic [WORD_W-1:0] w;
        w                = '0;
        w[BIT_LOCK]      = c.lock;
        w[BIT_HIDE_FAST] = c.hide_fast;
        w[BIT_HIDE_SYS]  = c.hide_sys;
        w[BIT_OWNER]     = c.owner_fast;
        return w;
    endfunction

    // Pick the implemented fields out of a register word.
    function automatic pin_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        pin_cfg_t c;
        c.lock       = w[BIT_LOCK];
        c.hide_fast  = w[BIT_HIDE_FAST];
        c.hide_sys   = w[BIT_HIDE_SYS];
        c.owner_fast = w[BIT_OWNER];
        return c;
    endfunction

endpackage

// File: rtl/gpio_own_cfg_bank.sv
// Module: per-pin configuration storage with a sticky lock.
// Assumes at least two pins. An index at or beyond NUM_PINS reads 0 and
// writes nothing. Reset is synchronous and active low.
module gpio_own_cfg_bank
    import gpio_own_pkg::*;
#(
    parameter int NUM_PINS = 128,
    localparam int IDX_W   = $clog2(NUM_PINS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic [IDX_W-1:0]              rd_idx,
    output logic [WORD_W-1:0]             rd_data,
    output pin_cfg_t [NUM_PINS-1:0]       cfg_q
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_cfg_t cfg_r;
        logic     hit;

        assign hit = wr_en && (wr_idx == IDX_W'(i));

        // Hold one pin word; an update is refused once the lock is set.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_r <= '0;
            else if (hit && !cfg_r.lock)
                cfg_r <= word_to_cfg(wr_data);
        end

        assign cfg_q[i] = cfg_r;

        p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_r.lock |=> cfg_r.lock);

        p_locked_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_r.lock |=> $stable(cfg_r));

        p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !cfg_r.lock) |=> (cfg_r == word_to_cfg($past(wr_data))));
    end

    // Return the addressed word; out-of-range indices read zero.
    always_comb begin
        if (32'(rd_idx) < NUM_PINS)
            rd_data = cfg_to_word(cfg_q[rd_idx]);
        else
            rd_data = '0;
    end

endmodule

// File: rtl/gpio_own_steer.sv
// Module: combinational pad steering and input masking for each pin.
// Assumes the configuration comes straight from registers.
module gpio_own_steer
    import gpio_own_pkg::*;
#(
    parameter int NUM_PINS = 128
) (
    input  pin_cfg_t [NUM_PINS-1:0] cfg,
    input  logic [NUM_PINS-1:0]     sys_out,
    input  logic [NUM_PINS-1:0]     sys_oe,
    input  logic [NUM_PINS-1:0]     fast_out,
    input  logic [NUM_PINS-1:0]     fast_oe,
    input  logic [NUM_PINS-1:0]     pad_in,
    output logic [NUM_PINS-1:0]     pad_out,
    output logic [NUM_PINS-1:0]     pad_oe,
    output logic [NUM_PINS-1:0]     sys_in,
    output logic [NUM_PINS-1:0]     fast_in
);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        // Owner drives the pad; the other controller is ignored.
        assign pad_out[i] = cfg[i].owner_fast ? fast_out[i] : sys_out[i];
        assign pad_oe[i]  = cfg[i].owner_fast ? fast_oe[i]  : sys_oe[i];
        // A hidden controller sees a constant zero.
        assign sys_in[i]  = pad_in[i] & ~cfg[i].hide_sys;
        assign fast_in[i] = pad_in[i] & ~cfg[i].hide_fast;
    end

endmodule

// File: rtl/gpio_own_mgr.sv
// Module: top of the pin ownership manager. Decodes byte addresses into
// pin indices (ports of PINS_PER_PORT words, four bytes each), holds the
// words and routes pads. Assumes PINS_PER_PORT is a power of two.
module gpio_own_mgr
    import gpio_own_pkg::*;
#(
    parameter int NUM_PORTS     = 4,
    parameter int PINS_PER_PORT = 32,
    localparam int NUM_PINS     = NUM_PORTS * PINS_PER_PORT,
    localparam int IDX_W        = $clog2(NUM_PINS),
    localparam int ADDR_W       = IDX_W + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_en,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    input  logic [NUM_PINS-1:0] sys_out,
    input  logic [NUM_PINS-1:0] sys_oe,
    output logic [NUM_PINS-1:0] sys_in,
    input  logic [NUM_PINS-1:0] fast_out,
    input  logic [NUM_PINS-1:0] fast_oe,
    output logic [NUM_PINS-1:0] fast_in,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);

    pin_cfg_t [NUM_PINS-1:0] cfg;
    logic     [IDX_W-1:0]    pin_idx;

    // Word index: drop the byte offset inside the word.
    assign pin_idx = reg_addr[ADDR_W-1:2];

    gpio_own_cfg_bank #(.NUM_PINS(NUM_PINS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_idx  (pin_idx),
        .wr_data (reg_wdata),
        .rd_idx  (pin_idx),
        .rd_data (reg_rdata),
        .cfg_q   (cfg)
    );

    gpio_own_steer #(.NUM_PINS(NUM_PINS)) u_steer (
        .cfg      (cfg),
        .sys_out  (sys_out),
        .sys_oe   (sys_oe),
        .fast_out (fast_out),
        .fast_oe  (fast_oe),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .sys_in   (sys_in),
        .fast_in  (fast_in)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        p_fast_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
            cfg[i].owner_fast |-> (pad_out[i] == fast_out[i] && pad_oe[i] == fast_oe[i]));

        p_sys_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg[i].owner_fast |-> (pad_out[i] == sys_out[i] && pad_oe[i] == sys_oe[i]));

        p_hide_sys_r4: assert property (@(posedge clk) disable iff (!rst_n)
            cfg[i].hide_sys |-> !sys_in[i]);

        p_hide_fast_r5: assert property (@(posedge clk) disable iff (!rst_n)
            cfg[i].hide_fast |-> !fast_in[i]);
    end

endmodule

// File: tb/tb_gpio_own_mgr.sv
module tb_gpio_own_mgr;
    localparam int NP   = 2;
    localparam int PP   = 32;
    localparam int NPIN = NP * PP;
    localparam int AW   = $clog2(NPIN) + 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reg_wr_en = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NPIN-1:0] sys_out  = {(NPIN/2){2'b01}};
    logic [NPIN-1:0] sys_oe   = {(NPIN/4){4'b0011}};
    logic [NPIN-1:0] fast_out = ~{(NPIN/2){2'b01}};
    logic [NPIN-1:0] fast_oe  = ~{(NPIN/4){4'b0011}};
    logic [NPIN-1:0] pad_in   = '1;
    logic [NPIN-1:0] sys_in, fast_in, pad_out, pad_oe;

    always #2 clk = ~clk;

    gpio_own_mgr #(.NUM_PORTS(NP), .PINS_PER_PORT(PP)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sys_out(sys_out), .sys_oe(sys_oe), .sys_in(sys_in),
        .fast_out(fast_out), .fast_oe(fast_oe), .fast_in(fast_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    typedef enum int {K_RD, K_POUT, K_POE, K_SIN, K_FIN} kind_t;
    typedef struct {
        kind_t       kind;
        int          idx;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];
    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 1'b0;

    // Monitor: pops expected items at each falling edge and compares.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    K_RD:    act = reg_rdata;
                    K_POUT:  act = {31'd0, pad_out[it.idx]};
                    K_POE:   act = {31'd0, pad_oe[it.idx]};
                    K_SIN:   act = {31'd0, sys_in[it.idx]};
                    default: act = {31'd0, fast_in[it.idx]};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_err++;
                    $display("FAIL %s kind=%0d pin=%0d actual=%h expected=%h",
                             it.req, it.kind, it.idx, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(kind_t k, int idx, logic [31:0] e, string req);
        item_t it;
        it.kind = k; it.idx = idx; it.exp = e; it.req = req;
        sb.push_back(it);
        wait (sb.size() == 0);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, logic [31:0] e, string req);
        @(posedge clk); #1;
        reg_addr = a;
        expect_item(K_RD, 0, e, req);
    endtask

    // Expected pad routing for a pin given its owner bit.
    task automatic chk_pad(int i, bit fast, string req);
        expect_item(K_POUT, i, {31'd0, fast ? fast_out[i] : sys_out[i]}, req);
        expect_item(K_POE,  i, {31'd0, fast ? fast_oe[i]  : sys_oe[i]},  req);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    function automatic void summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endfunction

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        rd(8'h00, 32'h0, "R1");
        rd(8'h84, 32'h0, "R1");
        chk_pad(5, 1'b0, "R1");
        expect_item(K_SIN, 5, 32'h1, "R1");
        expect_item(K_FIN, 40, 32'h1, "R1");

        // R3/R10/R11: pin 3 handed to fast GPIO; checked the cycle after the write
        wr(8'h0C, 32'h1);
        chk_pad(3, 1'b1, "R10");
        chk_pad(4, 1'b0, "R11");
        rd(8'h0C, 32'h1, "R2");
        pad_in[3] = 1'b0;
        expect_item(K_SIN, 3, 32'h0, "R3");
        pad_in[3] = 1'b1;

        // R9/R4/R5: all low bits set, port 1 pin 2 (pin 34)
        wr(8'h88, 32'h7FFF_FFFE);
        rd(8'h88, 32'h0000_0300, "R9");
        expect_item(K_SIN, 34, 32'h0, "R4");
        expect_item(K_FIN, 34, 32'h0, "R5");
        chk_pad(34, 1'b0, "R3");

        // R2: low address bits ignored
        wr(8'h8B, 32'h0000_0100);
        rd(8'h89, 32'h0000_0100, "R2");
        expect_item(K_SIN, 34, 32'h0, "R4");
        expect_item(K_FIN, 34, 32'h1, "R5");

        // R7: lock set together with owner and hide_fast on pin 5
        wr(8'h14, 32'h8000_0201);
        rd(8'h14, 32'h8000_0201, "R7");
        chk_pad(5, 1'b1, "R7");
        expect_item(K_FIN, 5, 32'h0, "R5");
        expect_item(K_SIN, 5, 32'h1, "R4");

        // R6: writes to a locked word have no effect
        wr(8'h14, 32'h0);
        rd(8'h14, 32'h8000_0201, "R6");
        chk_pad(5, 1'b1, "R6");
        wr(8'h14, 32'h0000_0100);
        rd(8'h14, 32'h8000_0201, "R6");
        expect_item(K_SIN, 5, 32'h1, "R6");

        // R11: neighbour stays writable
        wr(8'h18, 32'h1);
        rd(8'h18, 32'h1, "R11");

        // R8: reset releases the lock
        do_reset();
        rd(8'h14, 32'h0, "R8");
        chk_pad(5, 1'b0, "R8");
        expect_item(K_FIN, 5, 32'h1, "R8");
        rd(8'h0C, 32'h0, "R1");
        wr(8'h14, 32'h1);
        rd(8'h14, 32'h1, "R8");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule